// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Condition Flags

This block performs addition, subtraction and the bitwise operations AND, OR, XOR and NOT on two operands, at either a full 16-bit word width or an 8-bit byte width, under the control of a single width input. The result leaves the unit combinationally in the same cycle as the operands. Alongside it the unit derives six condition flags at the chosen width: carry or borrow, parity, nibble auxiliary carry, zero, sign and signed overflow.

The flags go into a status register. That register is loaded on a rising clock edge only when the flag write enable is high and the operation is one that defines flags. A surrounding datapath drives the operands and the opcode, reads the result at once, and sees the flags from the following cycle. Operations that do not define flags leave the stored flags alone. In byte mode only the low lane of each operand takes part, and the upper result bits read as zero.

Top module: `bw_alu`

## Requirements
- R1: Opcode 0 gives A+B and opcode 1 gives A−B, modulo the selected width. The result is valid combinationally in the same cycle as the inputs.
- R2: Opcodes 2, 3 and 4 give the bitwise AND, OR and XOR of A and B. Opcode 5 gives the bitwise inversion of A.
- R3: When `wide` is 0 (byte mode), only bits 7:0 of the operands are used and `result[15:8]` is 0. Every flag is then taken at bit 7 or bit 8 instead of bit 15 or bit 16. When `wide` is 1, all 16 bits are used.
- R4: Flag bit 0 (carry) is the carry out of the most significant bit for an add, and the borrow into it for a subtract. AND, OR and XOR clear it.
- R5: Flag bit 1 (parity) is 1 when bits 7:0 of the result hold an even number of ones, in both widths.
- R6: Flag bit 2 (auxiliary) is the carry (add) or borrow (subtract) from bit 3 into bit 4. AND, OR and XOR clear it.
- R7: Flag bit 3 (zero) is 1 exactly when the result at the selected width is zero. Flag bit 4 (sign) is the most significant bit of the result at the selected width.
- R8: Flag bit 5 (overflow) is 1 when an add or subtract leaves the signed range of the selected width. AND, OR and XOR clear it.
- R9: The flags output changes only at a rising clock edge where `flag_we` is 1, and shows the new value from that edge on. With `flag_we` at 0 the flags keep their value.
- R10: Opcode 5 and the reserved opcodes 6 and 7 leave the flags unchanged even when `flag_we` is 1. Opcodes 6 and 7 pass operand A through at the selected width.
- R11: An active-low `rst_n` clears all flags to 0 asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| op_sel | input | 3 | Opcode: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 not, 6/7 pass A |
| wide | input | 1 | 1 = 16-bit word, 0 = 8-bit byte |
| flag_we | input | 1 | Load the computed flags at the next edge |
| result | output | 16 | Operation result, zero-extended in byte mode |
| flags | output | 6 | Stored flags: bit 5 overflow, 4 sign, 3 zero, 2 aux, 1 parity, 0 carry |

## Verification
The result has no register in its path and is due in the same cycle as its operands. The bench therefore drives each vector at a falling edge and compares `result` one nanosecond later, before the next rising edge. The flags pass through exactly one register. They are compared one nanosecond after the rising edge that follows the vector, at which point they must already carry the new values (or, for NOT, pass-through or a cleared enable, the old ones). Asynchronous reset is checked one nanosecond after `rst_n` falls, with no clock edge in between.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4,
      OP_NOT = 3'd5
   } alu_op_e;

   // packed so that the carry lands in bit 0 and overflow in bit 5
   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic aux;
      logic par;
      logic cry;
   } stat_t;

   localparam int unsigned STAT_W = $bits(stat_t);

endpackage

// File: rtl/bw_alu_addsub.sv
module bw_alu_addsub #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned AUX_W  = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   input  logic              wide_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cry_o,
   output logic              aux_o,
   output logic              ovf_o
);
   localparam int unsigned NLANE = DATA_W / LANE_W;

   logic [DATA_W-1:0] b_eff;
   logic [NLANE:0]    lane_c;
   logic [AUX_W:0]    nib_sum;
   logic              c_top;
   logic              a_top;
   logic              b_top;
   logic              s_top;

   // subtraction as A + ~B + 1
   assign b_eff     = sub_i ? ~b_i : b_i;
   assign lane_c[0] = sub_i;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [LANE_W:0] part;
      assign part = {1'b0, a_i[g*LANE_W +: LANE_W]}
                  + {1'b0, b_eff[g*LANE_W +: LANE_W]}
                  + {{LANE_W{1'b0}}, lane_c[g]};
      assign sum_o[g*LANE_W +: LANE_W] = part[LANE_W-1:0];
      assign lane_c[g+1]               = part[LANE_W];
   end

   // carry across the nibble boundary, computed on its own short path
   assign nib_sum = {1'b0, a_i[AUX_W-1:0]}
                  + {1'b0, b_eff[AUX_W-1:0]}
                  + {{AUX_W{1'b0}}, sub_i};
   assign aux_o   = nib_sum[AUX_W] ^ sub_i;

   assign c_top = wide_i ? lane_c[NLANE] : lane_c[1];
   assign cry_o = c_top ^ sub_i;

   assign a_top = wide_i ? a_i[DATA_W-1]   : a_i[LANE_W-1];
   assign b_top = wide_i ? b_eff[DATA_W-1] : b_eff[LANE_W-1];
   assign s_top = wide_i ? sum_o[DATA_W-1] : sum_o[LANE_W-1];
   assign ovf_o = (a_top == b_top) && (s_top != a_top);

endmodule

// File: rtl/bw_alu_logic.sv
module bw_alu_logic
   import bw_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);
   always_comb begin
      case (op_i)
         OP_AND:  y_o = a_i & b_i;
         OP_OR:   y_o = a_i | b_i;
         OP_XOR:  y_o = a_i ^ b_i;
         OP_NOT:  y_o = ~a_i;
         default: y_o = a_i;
      endcase
   end
endmodule

// File: rtl/bw_alu_flaggen.sv
module bw_alu_flaggen #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned LANE_W    = 8,
   parameter int unsigned PAR_W     = 8,
   parameter bit          PAR_CHAIN = 1'b0
) (
   input  logic [DATA_W-1:0] res_i,
   input  logic              wide_i,
   output logic              zro_o,
   output logic              sgn_o,
   output logic              par_o
);
   // the result is already masked to the active width
   assign zro_o = ~|res_i;
   assign sgn_o = wide_i ? res_i[DATA_W-1] : res_i[LANE_W-1];

   if (PAR_CHAIN) begin : g_par_chain
      logic [PAR_W:0] acc;
      assign acc[0] = 1'b1;
      for (genvar k = 0; k < PAR_W; k++) begin : g_bit
         assign acc[k+1] = acc[k] ^ res_i[k];
      end
      assign par_o = acc[PAR_W];
   end else begin : g_par_tree
      assign par_o = ~^res_i[PAR_W-1:0];
   end
endmodule

// File: rtl/bw_alu_status.sv
module bw_alu_status #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (we_i)
         q_o <= d_i;
   end
endmodule

// File: rtl/bw_alu.sv
module bw_alu
   import bw_alu_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned LANE_W    = 8,
   parameter int unsigned AUX_W     = 4,
   parameter int unsigned PAR_W     = 8,
   parameter bit          PAR_CHAIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [2:0]        op_sel,
   input  logic              wide,
   input  logic              flag_we,
   output logic [DATA_W-1:0] result,
   output logic [STAT_W-1:0] flags
);
   localparam logic [DATA_W-1:0] LANE_MASK = {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

   if ((DATA_W % LANE_W) != 0 || DATA_W < 2*LANE_W) begin : g_bad_width
      $error("bw_alu: DATA_W must be a multiple of LANE_W and at least two lanes");
   end
   if (AUX_W == 0 || AUX_W >= LANE_W) begin : g_bad_aux
      $error("bw_alu: AUX_W must lie inside one lane");
   end
   if (PAR_W == 0 || PAR_W > LANE_W) begin : g_bad_par
      $error("bw_alu: PAR_W must not exceed one lane");
   end

   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] bit_y;
   logic [DATA_W-1:0] raw;
   logic              a_cry, a_aux, a_ovf;
   logic              f_zro, f_sgn, f_par;
   logic              is_arith;
   logic              defines_flags;
   stat_t             nxt;

   assign is_arith      = (op_sel == OP_ADD) || (op_sel == OP_SUB);
   assign defines_flags = is_arith || (op_sel == OP_AND) || (op_sel == OP_OR)
                       || (op_sel == OP_XOR);

   bw_alu_addsub #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W),
      .AUX_W  (AUX_W)
   ) u_addsub (
      .a_i    (opnd_a),
      .b_i    (opnd_b),
      .sub_i  (op_sel == OP_SUB),
      .wide_i (wide),
      .sum_o  (sum),
      .cry_o  (a_cry),
      .aux_o  (a_aux),
      .ovf_o  (a_ovf)
   );

   bw_alu_logic #(
      .DATA_W (DATA_W)
   ) u_logic (
      .op_i (op_sel),
      .a_i  (opnd_a),
      .b_i  (opnd_b),
      .y_o  (bit_y)
   );

   assign raw    = is_arith ? sum : bit_y;
   assign result = wide ? raw : (raw & LANE_MASK);

   bw_alu_flaggen #(
      .DATA_W    (DATA_W),
      .LANE_W    (LANE_W),
      .PAR_W     (PAR_W),
      .PAR_CHAIN (PAR_CHAIN)
   ) u_flaggen (
      .res_i  (result),
      .wide_i (wide),
      .zro_o  (f_zro),
      .sgn_o  (f_sgn),
      .par_o  (f_par)
   );

   always_comb begin
      nxt     = '0;
      nxt.cry = is_arith & a_cry;
      nxt.aux = is_arith & a_aux;
      nxt.ovf = is_arith & a_ovf;
      nxt.zro = f_zro;
      nxt.sgn = f_sgn;
      nxt.par = f_par;
   end

   bw_alu_status #(
      .W (STAT_W)
   ) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (flag_we & defines_flags),
      .d_i   (nxt),
      .q_o   (flags)
   );

endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] opnd_a,
   input logic [2:0]        op_sel,
   input logic              wide,
   input logic              flag_we,
   input logic [DATA_W-1:0] result,
   input logic [5:0]        flags
);
   // R9
   no_we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we |=> $stable(flags));

   // R10
   not_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel >= 3'd5) |=> $stable(flags));

   // R4 R6 R8
   logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel >= 3'd2 && op_sel <= 3'd4)
         |=> (flags[0] == 1'b0 && flags[2] == 1'b0 && flags[5] == 1'b0));

   // R7
   zero_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel <= 3'd4) |=> (flags[3] == ($past(result) == '0)));

   // R3
   byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wide |-> (result[DATA_W-1:LANE_W] == '0));

   // R2
   not_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd5 && wide) |-> (result == ~opnd_a));
endmodule

bind bw_alu bw_alu_chk #(
   .DATA_W (DATA_W),
   .LANE_W (LANE_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .opnd_a  (opnd_a),
   .op_sel  (op_sel),
   .wide    (wide),
   .flag_we (flag_we),
   .result  (result),
   .flags   (flags)
);

// File: tb/bw_alu_test.sv
`timescale 1ns/1ps
module bw_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] opnd_a = '0;
   logic [15:0] opnd_b = '0;
   logic [2:0]  op_sel = '0;
   logic        wide = 1'b1;
   logic        flag_we = 1'b0;
   logic [15:0] result;
   logic [5:0]  flags;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   bw_alu uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b),
      .op_sel  (op_sel),
      .wide    (wide),
      .flag_we (flag_we),
      .result  (result),
      .flags   (flags)
   );

   // entry: {op, wide, A, B, expected result, expected flags}
   // flags: [5] ovf [4] sign [3] zero [2] aux [1] parity [0] carry
   localparam int NV = 16;
   localparam logic [57:0] VEC [NV] = '{
      {3'd0, 1'b1, 16'h1234, 16'h4321, 16'h5555, 6'h02},
      {3'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 6'h0F},
      {3'd0, 1'b0, 16'hAB7F, 16'hCD01, 16'h0080, 6'h34},
      {3'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 6'h36},
      {3'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 6'h0F},
      {3'd1, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 6'h17},
      {3'd1, 1'b0, 16'h0080, 16'h0001, 16'h007F, 6'h24},
      {3'd1, 1'b1, 16'h5000, 16'h5000, 16'h0000, 6'h0A},
      {3'd1, 1'b1, 16'h8000, 16'h0001, 16'h7FFF, 6'h26},
      {3'd2, 1'b1, 16'hF0F0, 16'h0FFF, 16'h00F0, 6'h02},
      {3'd3, 1'b0, 16'h1280, 16'h3401, 16'h0081, 6'h12},
      {3'd4, 1'b1, 16'hAAAA, 16'hAAAA, 16'h0000, 6'h0A},
      {3'd4, 1'b1, 16'h8001, 16'h0000, 16'h8001, 6'h10},
      {3'd5, 1'b1, 16'h00FF, 16'h5555, 16'hFF00, 6'h10},
      {3'd5, 1'b0, 16'h1234, 16'h0000, 16'h00CB, 6'h10},
      {3'd1, 1'b0, 16'h0010, 16'h0020, 16'h00F0, 6'h13}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic w, input logic [15:0] a,
                        input logic [15:0] b, input logic we);
      @(negedge clk);
      op_sel  = op;
      wide    = w;
      opnd_a  = a;
      opnd_b  = b;
      flag_we = we;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R11: flags clear while reset is held
      repeat (2) @(posedge clk);
      #1;
      chk("R11 reset flags", {10'd0, flags}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk; result same cycle (R1 R2 R3), flags after one edge (R4 R5 R6 R7 R8 R9)
      for (int i = 0; i < NV; i++) begin
         logic [2:0]  v_op;
         logic        v_w;
         logic [15:0] v_a, v_b, v_r;
         logic [5:0]  v_f;
         {v_op, v_w, v_a, v_b, v_r, v_f} = VEC[i];
         apply(v_op, v_w, v_a, v_b, 1'b1);
         if (v_op <= 3'd1)
            chk(v_w ? "R1 result" : "R1 R3 byte result", result, v_r);
         else
            chk(v_w ? "R2 result" : "R2 R3 byte result", result, v_r);
         @(posedge clk);
         #1;
         if (v_op == 3'd5)
            chk("R10 flags kept on NOT", {10'd0, flags}, {10'd0, v_f});
         else
            chk("R4 R5 R6 R7 R8 flags", {10'd0, flags}, {10'd0, v_f});
      end

      // R9: enable low, an add that would set carry/zero must not touch flags
      apply(3'd0, 1'b1, 16'hFFFF, 16'h0001, 1'b0);
      chk("R1 result with enable low", result, 16'h0000);
      @(posedge clk);
      #1;
      chk("R9 flags hold without enable", {10'd0, flags}, 16'h0013);

      // R10: reserved opcodes pass A and keep flags
      apply(3'd6, 1'b1, 16'hBEEF, 16'h1234, 1'b1);
      chk("R10 reserved word pass", result, 16'hBEEF);
      @(posedge clk);
      #1;
      chk("R10 reserved keeps flags", {10'd0, flags}, 16'h0013);
      apply(3'd7, 1'b0, 16'hBEEF, 16'h1234, 1'b1);
      chk("R10 R3 reserved byte pass", result, 16'h00EF);
      @(posedge clk);
      #1;
      chk("R10 reserved byte keeps flags", {10'd0, flags}, 16'h0013);

      // R11: asynchronous clear mid-run, no clock edge needed
      @(negedge clk);
      flag_we = 1'b0;
      rst_n   = 1'b0;
      #1;
      chk("R11 async clear", {10'd0, flags}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // R6: nibble carry alone; parity of 0x10 is odd
      apply(3'd0, 1'b1, 16'h0008, 16'h0008, 1'b1);
      chk("R1 nibble add result", result, 16'h0010);
      @(posedge clk);
      #1;
      chk("R6 aux only", {10'd0, flags}, 16'h0004);

      // R5: parity uses the low byte only in word mode (0x0300 -> low byte 0, even)
      apply(3'd3, 1'b1, 16'h0100, 16'h0200, 1'b1);
      @(posedge clk);
      #1;
      chk("R5 parity low byte", {10'd0, flags}, 16'h0002);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule